// File: doc/BRIEF.md
# Programmable Parallel Port with Handshake

This block is a general-purpose parallel interface with three byte-wide ports: A, B and C. A host reaches it through a synchronous register interface. The interface has a 2-bit address, a chip select, and read and write strobes. Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register. Port C is split into an upper nibble (bits 7..4) and a lower nibble (bits 3..0). Each nibble has its own direction. In the strobed modes, several port C lines are taken over as handshake and interrupt lines. The block never drives a pin itself: each port has an output value and a separate output-enable vector.

Bit 7 of a control write selects what the write means. With bit 7 set, the write is a configuration word with these fields: bits 6..5 give the group A mode (0 simple, 1 strobed, 2 or 3 bidirectional), bit 4 sets port A as input, bit 3 sets upper C as input, bit 2 sets group B as strobed, bit 1 sets port B as input, and bit 0 sets lower C as input. With bit 7 clear, the write sets or clears a single port C latch bit. Bits 3..1 give the bit index and bit 0 gives the new value. Reset loads the all-inputs, simple-mode configuration.

Top module: `paraport`

## Requirements
- R1: While reset is held, and after it is released, all output-enable vectors are zero and all output latches are zero. Port A then reads its pins directly.
- R2: In simple mode with a port set as output, a host write to that port latches the byte. The port then drives the byte with all eight enables high, and a host read returns the latched byte.
- R3: In simple mode with a port set as input, the enables are zero and a host read returns the live pin value.
- R4: In simple mode the two port C nibbles take their directions independently. A port C read returns the pin value on input bits and the latch value on output bits.
- R5: A control write with bit 7 clear changes only the port C latch bit indexed by bits 3..1, setting it to bit 0.
- R6: Any configuration write clears the port A and port B output latches, all port C latch bits (including the interrupt-enable bits), and all buffer flags and interrupt requests.
- R7: In strobed input mode, a low strobe (PC4 for port A, PC2 for port B) latches the port pins and raises input-full (PC5 for A, PC1 for B). A host read of that port returns the latched byte and clears input-full.
- R8: In strobed output mode, a host write to the port drives the active-low output-full line low (PC7 for A, PC1 for B). A low acknowledge (PC6 for A, PC2 for B) returns it high.
- R9: The interrupt request (PC3 for A, PC0 for B) rises one cycle after the strobe or acknowledge returns high. It needs the matching condition (input-full set, or output-full released) and the port's enable latch bit (PC4 latch for A input, PC6 latch for A output, PC2 latch for B). The request clears on the next host read (input) or write (output) of that port. With the enable bit clear, the request stays low.
- R10: In bidirectional mode, port A drives its output latch only while PC6 is low and is otherwise undriven. Port A always drives or releases all eight lines together. Its input and output are both latched. The upper C handshake lines are fixed (PC3, PC5 and PC7 outputs; PC4 and PC6 inputs), and PC2..PC0 remain plain lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Host read strobe, one cycle per access |
| wr | input | 1 | Host write strobe, one cycle per access |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational, zero when not reading |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A output values |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B output values |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin inputs, including strobe and acknowledge |
| pcOut | output | 8 | Port C output values, including flags and requests |
| pcOe | output | 8 | Port C output enables |

## Verification
The assertions assume that strobe and acknowledge are synchronous to the clock and are sampled like any other input. They also assume that the host never accesses a port in the same cycle as that port's strobe or acknowledge is low, and that a configuration write never coincides with a strobe. The handshake mode is inferred from the port C enable pattern, which is possible because the simple mode always gives a whole nibble one direction. The stimulus changes every pin and host signal on the falling clock edge. It holds strobe and acknowledge high except for single low cycles placed away from host accesses, and it issues each host access as a one-cycle pulse.

// File: rtl/paraport_pkg.sv
package paraport_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;
  localparam int SEL_W = $clog2(PORT_W);

  localparam logic [ADDR_W-1:0] ADDR_A   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_B   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_C   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd3;

  // configuration loaded at reset: all ports input, simple mode
  localparam logic [PORT_W-1:0] RESET_CFG = 8'h9B;

  // port C line roles in the strobed modes
  localparam int PIN_INTR_A = 3;
  localparam int PIN_STB_A  = 4;
  localparam int PIN_IBF_A  = 5;
  localparam int PIN_ACK_A  = 6;
  localparam int PIN_OBF_A  = 7;
  localparam int PIN_INTR_B = 0;
  localparam int PIN_FLAG_B = 1;
  localparam int PIN_HS_B   = 2;

  typedef enum logic [1:0] {
    GRP_SIMPLE  = 2'd0,
    GRP_STROBED = 2'd1,
    GRP_BIDIR   = 2'd2
  } grpMode_e;

  typedef struct packed {
    grpMode_e modeA;
    logic     aDirIn;
    logic     cUpIn;
    logic     modeB;
    logic     bDirIn;
    logic     cLoIn;
  } portCfg_t;

  typedef struct packed {
    logic latchAOut;
    logic latchBOut;
    logic capA;
    logic capB;
    logic clrAll;
  } dpStrobe_t;

  typedef struct packed {
    logic ibfA;
    logic obfA;
    logic intrA;
    logic ibfB;
    logic obfB;
    logic intrB;
  } hsStatus_t;

  function automatic portCfg_t cfgFromWord(input logic [PORT_W-1:0] w);
    portCfg_t c;
    c.modeA  = w[6] ? GRP_BIDIR : (w[5] ? GRP_STROBED : GRP_SIMPLE);
    c.aDirIn = w[4];
    c.cUpIn  = w[3];
    c.modeB  = w[2];
    c.bDirIn = w[1];
    c.cLoIn  = w[0];
    return c;
  endfunction

  function automatic logic aInHs(input portCfg_t c);
    return (c.modeA == GRP_STROBED && c.aDirIn) || c.modeA == GRP_BIDIR;
  endfunction

  function automatic logic aOutHs(input portCfg_t c);
    return (c.modeA == GRP_STROBED && !c.aDirIn) || c.modeA == GRP_BIDIR;
  endfunction
endpackage

// File: rtl/paraport_hs.sv
module paraport_hs (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic inEn,
  input  logic outEn,
  input  logic stbN,
  input  logic ackN,
  input  logic inteIn,
  input  logic inteOut,
  input  logic hostRd,
  input  logic hostWr,
  output logic ibf,
  output logic obf,
  output logic intr,
  output logic capture
);
  logic stbPrev, ackPrev, setIntr, inAccess, outAccess;

  assign capture   = inEn & ~stbN;
  assign inAccess  = hostRd & inEn;
  assign outAccess = hostWr & outEn;
  assign setIntr   = (inEn & ~stbPrev & stbN & ibf & inteIn) |
                     (outEn & ~ackPrev & ackN & ~obf & inteOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPrev <= 1'b1;
      ackPrev <= 1'b1;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      intr    <= 1'b0;
    end else begin
      stbPrev <= stbN;
      ackPrev <= ackN;
      if (clr) begin
        ibf  <= 1'b0;
        obf  <= 1'b0;
        intr <= 1'b0;
      end else begin
        if (capture) ibf <= 1'b1;
        else if (inAccess) ibf <= 1'b0;
        if (outAccess) obf <= 1'b1;
        else if (outEn && !ackN) obf <= 1'b0;
        if (setIntr) intr <= 1'b1;
        else if (inAccess || outAccess) intr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/paraport_ctrl.sv
module paraport_ctrl
  import paraport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pcIn,
  output portCfg_t          cfg,
  output dpStrobe_t         stb,
  output hsStatus_t         status,
  output logic [PORT_W-1:0] pcLatch
);
  logic wrA, wrB, wrC, wrCtl, rdA, rdB, modeSet;
  logic aInEn, aOutEn, bInEn, bOutEn, capA, capB;

  assign wrA     = cs & wr & (addr == ADDR_A);
  assign wrB     = cs & wr & (addr == ADDR_B);
  assign wrC     = cs & wr & (addr == ADDR_C);
  assign wrCtl   = cs & wr & (addr == ADDR_CTL);
  assign rdA     = cs & rd & (addr == ADDR_A);
  assign rdB     = cs & rd & (addr == ADDR_B);
  assign modeSet = wrCtl & wdata[PORT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= cfgFromWord(RESET_CFG);
      pcLatch <= '0;
    end else if (modeSet) begin
      cfg     <= cfgFromWord(wdata);
      pcLatch <= '0;
    end else if (wrCtl) begin
      pcLatch[wdata[SEL_W:1]] <= wdata[0];
    end else if (wrC) begin
      pcLatch <= wdata;
    end
  end

  assign aInEn  = aInHs(cfg);
  assign aOutEn = aOutHs(cfg);
  assign bInEn  = cfg.modeB & cfg.bDirIn;
  assign bOutEn = cfg.modeB & ~cfg.bDirIn;

  paraport_hs i_hsA (
    .clk(clk), .rstN(rstN), .clr(modeSet),
    .inEn(aInEn), .outEn(aOutEn),
    .stbN(pcIn[PIN_STB_A]), .ackN(pcIn[PIN_ACK_A]),
    .inteIn(pcLatch[PIN_STB_A]), .inteOut(pcLatch[PIN_ACK_A]),
    .hostRd(rdA), .hostWr(wrA),
    .ibf(status.ibfA), .obf(status.obfA), .intr(status.intrA),
    .capture(capA)
  );

  paraport_hs i_hsB (
    .clk(clk), .rstN(rstN), .clr(modeSet),
    .inEn(bInEn), .outEn(bOutEn),
    .stbN(pcIn[PIN_HS_B]), .ackN(pcIn[PIN_HS_B]),
    .inteIn(pcLatch[PIN_HS_B]), .inteOut(pcLatch[PIN_HS_B]),
    .hostRd(rdB), .hostWr(wrB),
    .ibf(status.ibfB), .obf(status.obfB), .intr(status.intrB),
    .capture(capB)
  );

  assign stb.latchAOut = wrA;
  assign stb.latchBOut = wrB;
  assign stb.capA      = capA;
  assign stb.capB      = capB;
  assign stb.clrAll    = modeSet;
endmodule

// File: rtl/paraport_dp.sv
module paraport_dp
  import paraport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portCfg_t          cfg,
  input  dpStrobe_t         stb,
  input  hsStatus_t         status,
  input  logic [PORT_W-1:0] pcLatch,
  input  logic [PORT_W-1:0] wdata,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] paIn,
  input  logic [PORT_W-1:0] pbIn,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] paOe,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pbOe,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] pcOe,
  output logic [PORT_W-1:0] rdata
);
  localparam int NIB_W = PORT_W / 2;

  logic [PORT_W-1:0] aOutQ, bOutQ, aInQ, bInQ, aRd, bRd, cRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOutQ <= '0;
      bOutQ <= '0;
      aInQ  <= '0;
      bInQ  <= '0;
    end else if (stb.clrAll) begin
      aOutQ <= '0;
      bOutQ <= '0;
      aInQ  <= '0;
      bInQ  <= '0;
    end else begin
      if (stb.latchAOut) aOutQ <= wdata;
      if (stb.latchBOut) bOutQ <= wdata;
      if (stb.capA) aInQ <= paIn;
      if (stb.capB) bInQ <= pbIn;
    end
  end

  assign paOut = aOutQ;
  assign pbOut = bOutQ;
  assign paOe  = (cfg.modeA == GRP_BIDIR) ? {PORT_W{~pcIn[PIN_ACK_A]}}
                                          : {PORT_W{~cfg.aDirIn}};
  assign pbOe  = {PORT_W{~cfg.bDirIn}};

  always_comb begin
    pcOe  = {{NIB_W{~cfg.cUpIn}}, {NIB_W{~cfg.cLoIn}}};
    pcOut = pcLatch;
    if (cfg.modeA != GRP_SIMPLE) begin
      pcOe[PIN_INTR_A]  = 1'b1;
      pcOut[PIN_INTR_A] = status.intrA;
    end
    if (aInHs(cfg)) begin
      pcOe[PIN_STB_A]  = 1'b0;
      pcOe[PIN_IBF_A]  = 1'b1;
      pcOut[PIN_IBF_A] = status.ibfA;
    end
    if (aOutHs(cfg)) begin
      pcOe[PIN_ACK_A]  = 1'b0;
      pcOe[PIN_OBF_A]  = 1'b1;
      pcOut[PIN_OBF_A] = ~status.obfA;
    end
    if (cfg.modeB) begin
      pcOe[PIN_HS_B]    = 1'b0;
      pcOe[PIN_FLAG_B]  = 1'b1;
      pcOe[PIN_INTR_B]  = 1'b1;
      pcOut[PIN_FLAG_B] = cfg.bDirIn ? status.ibfB : ~status.obfB;
      pcOut[PIN_INTR_B] = status.intrB;
    end
  end

  assign aRd = (cfg.modeA == GRP_SIMPLE) ? (cfg.aDirIn ? paIn : aOutQ)
                                         : (aInHs(cfg) ? aInQ : aOutQ);
  assign bRd = !cfg.modeB ? (cfg.bDirIn ? pbIn : bOutQ)
                          : (cfg.bDirIn ? bInQ : bOutQ);
  assign cRd = (pcOe & pcOut) | (~pcOe & pcIn);

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      unique case (addr)
        ADDR_A:  rdata = aRd;
        ADDR_B:  rdata = bRd;
        ADDR_C:  rdata = cRd;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/paraport.sv
module paraport
  import paraport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] paIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] paOe,
  input  logic [PORT_W-1:0] pbIn,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pbOe,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] pcOe
);
  portCfg_t          cfg;
  dpStrobe_t         stb;
  hsStatus_t         status;
  logic [PORT_W-1:0] pcLatch;

  paraport_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .pcIn(pcIn), .cfg(cfg), .stb(stb), .status(status),
    .pcLatch(pcLatch)
  );

  paraport_dp i_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .status(status),
    .pcLatch(pcLatch), .wdata(wdata), .rdEn(cs & rd), .addr(addr),
    .paIn(paIn), .pbIn(pbIn), .pcIn(pcIn),
    .paOut(paOut), .paOe(paOe), .pbOut(pbOut), .pbOe(pbOe),
    .pcOut(pcOut), .pcOe(pcOe), .rdata(rdata)
  );
endmodule

// File: rtl/paraport_chk.sv
module paraport_chk
  import paraport_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [PORT_W-1:0] wdata,
  input logic [PORT_W-1:0] paOut,
  input logic [PORT_W-1:0] paOe,
  input logic [PORT_W-1:0] pbOut,
  input logic [PORT_W-1:0] pbOe,
  input logic [PORT_W-1:0] pcIn,
  input logic [PORT_W-1:0] pcOut,
  input logic [PORT_W-1:0] pcOe
);
  logic rstSeen, ctlWr, aHsIn, aHsOut, aHs;

  assign ctlWr  = cs && wr && addr == ADDR_CTL;
  assign aHsIn  = !pcOe[PIN_STB_A] && pcOe[PIN_IBF_A];
  assign aHsOut = !pcOe[PIN_ACK_A] && pcOe[PIN_OBF_A];
  assign aHs    = aHsIn || aHsOut;

  always_ff @(posedge clk) rstSeen <= !rstN;

  // R1: reset holds every enable and latch at zero
  always @(posedge clk)
    if (!rstN && rstSeen)
      assert_reset_idle_R1: assert (paOe == '0 && pbOe == '0 && pcOe == '0 &&
                                    paOut == '0 && pbOut == '0);

  assert_port_whole_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(paOe) == 0 || $countones(paOe) == PORT_W);

  assert_modeset_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wdata[PORT_W-1]) |=> (paOut == '0 && pbOut == '0));

  assert_ibf_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (aHsIn && !pcIn[PIN_STB_A] && !ctlWr) |=> (pcOut[PIN_IBF_A] || !aHsIn));

  assert_obf_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (aHsOut && cs && wr && addr == ADDR_A && pcIn[PIN_ACK_A])
      |=> (!pcOut[PIN_OBF_A] || !aHsOut));

  assert_intr_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (aHs && $past(aHs) && $rose(pcOut[PIN_INTR_A])) |->
      (($past(pcIn[PIN_STB_A]) && !$past(pcIn[PIN_STB_A], 2)) ||
       ($past(pcIn[PIN_ACK_A]) && !$past(pcIn[PIN_ACK_A], 2))));
endmodule

bind paraport paraport_chk i_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
  .paOut(paOut), .paOe(paOe), .pbOut(pbOut), .pbOe(pbOe),
  .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
);

// File: tb/test_paraport.sv
module test_paraport;
  import paraport_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [PORT_W-1:0] wdata = '0, paIn = 8'h3C, pbIn = '0, pcIn = 8'hFF;
  logic [PORT_W-1:0] rdata, paOut, paOe, pbOut, pbOe, pcOut, pcOe;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  paraport i_paraport (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe), .pcIn(pcIn), .pcOut(pcOut),
    .pcOe(pcOe)
  );

  // {control word, port A write, port A pins, expected enables, expected read}
  localparam logic [39:0] VEC [5] = '{
    {8'h80, 8'h5A, 8'hFF, 8'hFF, 8'h5A},
    {8'h90, 8'h5A, 8'h3C, 8'h00, 8'h3C},
    {8'h80, 8'hC3, 8'h00, 8'hFF, 8'hC3},
    {8'h9B, 8'h11, 8'hA5, 8'h00, 8'hA5},
    {8'h82, 8'hE7, 8'h81, 8'hFF, 8'hE7}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    tick();
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic hostRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    tick();
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 paOe in reset", paOe, 8'h00);
    rstN = 1'b1;
    tick();
    chk("R1 pcOe after reset", pcOe, 8'h00);
    chk("R1 pbOe after reset", pbOe, 8'h00);
    chk("R1 paOut after reset", paOut, 8'h00);
    hostRead(ADDR_A, v);
    chk("R1 port A reads pins", v, 8'h3C);

    // simple mode table: R2 output ports, R3 input ports
    for (int i = 0; i < 5; i++) begin
      hostWrite(ADDR_CTL, VEC[i][39:32]);
      hostWrite(ADDR_A, VEC[i][31:24]);
      paIn = VEC[i][23:16];
      hostRead(ADDR_A, v);
      chk("R2/R3 port A enables", paOe, VEC[i][15:8]);
      chk("R2/R3 port A read", v, VEC[i][7:0]);
      if (VEC[i][15:8] != 8'h00) chk("R2 port A drive", paOut, VEC[i][31:24]);
    end

    // R4: upper C input, lower C output
    pcIn = 8'h5F;
    hostWrite(ADDR_CTL, 8'h88);
    chk("R4 nibble enables", pcOe, 8'h0F);
    hostWrite(ADDR_C, 8'hA6);
    hostRead(ADDR_C, v);
    chk("R4 merged C read", v, 8'h56);
    pcIn = 8'hFF;

    // R5: single bit set/reset
    hostWrite(ADDR_CTL, 8'h81);
    hostWrite(ADDR_C, 8'h00);
    hostWrite(ADDR_CTL, 8'h0B);
    chk("R5 set bit 5", pcOut, 8'h20);
    hostWrite(ADDR_CTL, 8'h0D);
    hostWrite(ADDR_CTL, 8'h0A);
    chk("R5 set 6 clear 5", pcOut, 8'h40);

    // R6: configuration write clears latches
    hostWrite(ADDR_CTL, 8'h80);
    hostWrite(ADDR_A, 8'hFF);
    hostWrite(ADDR_B, 8'hFF);
    hostWrite(ADDR_C, 8'hFF);
    hostWrite(ADDR_CTL, 8'h80);
    chk("R6 port A cleared", paOut, 8'h00);
    chk("R6 port B cleared", pbOut, 8'h00);
    chk("R6 port C cleared", pcOut, 8'h00);

    // R7 and R9: port A strobed input with interrupt enabled
    hostWrite(ADDR_CTL, 8'hB0);
    chk("R7 C enables strobed in", pcOe, 8'hEF);
    chk("R7 port A undriven", paOe, 8'h00);
    hostWrite(ADDR_CTL, 8'h09);
    paIn = 8'h77;
    pcIn[4] = 1'b0;
    tick();
    chk("R7 input full set", {7'd0, pcOut[5]}, 8'h01);
    chk("R9 no request while strobe low", {7'd0, pcOut[3]}, 8'h00);
    pcIn[4] = 1'b1;
    tick();
    chk("R9 request after strobe rise", {7'd0, pcOut[3]}, 8'h01);
    paIn = 8'h00;
    hostRead(ADDR_A, v);
    chk("R7 latched data", v, 8'h77);
    chk("R7 input full cleared", {7'd0, pcOut[5]}, 8'h00);
    chk("R9 request cleared by read", {7'd0, pcOut[3]}, 8'h00);

    // R9: enable clear keeps the request low
    hostWrite(ADDR_CTL, 8'h08);
    pcIn[4] = 1'b0;
    tick();
    pcIn[4] = 1'b1;
    tick();
    chk("R9 disabled request", {7'd0, pcOut[3]}, 8'h00);
    chk("R7 input full without enable", {7'd0, pcOut[5]}, 8'h01);
    hostRead(ADDR_A, v);

    // R8 and R9: port B strobed output
    hostWrite(ADDR_CTL, 8'h84);
    hostWrite(ADDR_CTL, 8'h05);
    hostWrite(ADDR_B, 8'h3E);
    chk("R8 port B drive", pbOut, 8'h3E);
    chk("R8 port B enables", pbOe, 8'hFF);
    chk("R8 output full low", {7'd0, pcOut[1]}, 8'h00);
    pcIn[2] = 1'b0;
    tick();
    chk("R8 ack releases output full", {7'd0, pcOut[1]}, 8'h01);
    chk("R9 no request while ack low", {7'd0, pcOut[0]}, 8'h00);
    pcIn[2] = 1'b1;
    tick();
    chk("R9 B request after ack", {7'd0, pcOut[0]}, 8'h01);
    hostWrite(ADDR_B, 8'h41);
    chk("R9 B request cleared by write", {7'd0, pcOut[0]}, 8'h00);
    chk("R8 output full again", {7'd0, pcOut[1]}, 8'h00);

    // R10: bidirectional port A
    hostWrite(ADDR_CTL, 8'hC0);
    chk("R10 C enables", pcOe, 8'hAF);
    chk("R10 undriven with ack high", paOe, 8'h00);
    hostWrite(ADDR_A, 8'h9C);
    chk("R10 output full low", {7'd0, pcOut[7]}, 8'h00);
    pcIn[6] = 1'b0;
    #1;
    chk("R10 drives while ack low", paOe, 8'hFF);
    chk("R10 driven value", paOut, 8'h9C);
    tick();
    chk("R10 output full released", {7'd0, pcOut[7]}, 8'h01);
    pcIn[6] = 1'b1;
    tick();
    chk("R10 released after ack", paOe, 8'h00);
    paIn = 8'h44;
    pcIn[4] = 1'b0;
    tick();
    pcIn[4] = 1'b1;
    paIn = 8'h00;
    tick();
    chk("R10 input full", {7'd0, pcOut[5]}, 8'h01);
    hostRead(ADDR_A, v);
    chk("R10 latched input", v, 8'h44);
    hostWrite(ADDR_CTL, 8'h01);
    chk("R10 plain low lines", pcOut & 8'h07, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule